// File: doc/BRIEF.md
# Glitch-Assisted Protected Memory Read Sequencer

This block automates byte-by-byte extraction of memory from a target whose debug port is locked. For each byte it drives a byte-level debug transfer engine through a fixed twelve-step exchange. Step one has the target execute a three-byte pointer-load instruction that carries the 16-bit address. Step two has it execute a one-byte fetch instruction that copies the byte at that pointer into the accumulator. Each instruction is followed at once by a status read. A one-cycle fault trigger is fired right after each instruction-execute command byte has gone out. The target is powered off for a fixed number of cycles before every attempt, so each attempt begins from a clean state.

An attempt counts only when both status reads report the port unlocked. The lock returns before every instruction, so the two instructions each need their own fault in the same attempt. If the status after the first instruction still shows the lock, the second instruction is skipped. On any failure the same address is tried again after a power cycle. On success the block presents the address and data for one cycle, bumps its counters and moves on, until the end address has been read.

Top module: `gsr_read_seq`

## Requirements
- R1: After reset the block holds the target powered off and the transfer request low. The fault trigger, the read strobe and `done` are low, and both counters read zero.
- R2: Each attempt issues transfers in this order, one request per completed transfer (send = 1 means a byte to the target): send CMD_LONG (0x57), send OP_LOAD (0x90), send address high byte, send address low byte, receive, send CMD_STATUS (0x34), receive, send CMD_SHORT (0x55), send OP_FETCH (0xE0), receive, send CMD_STATUS, receive.
- R3: `glitch_fire` is high for exactly the one cycle after the acknowledge of a CMD_LONG or CMD_SHORT transfer, and at no other time.
- R4: A status byte with bit 2 (LOCK_BIT) set, received after the pointer-load instruction, ends the attempt. No CMD_SHORT is issued, and the next attempt uses the same address.
- R5: A status byte with bit 2 set, received after the fetch instruction, discards the attempt. No read is reported, and the next attempt uses the same address.
- R6: When both status bytes have bit 2 clear, `rd_valid` pulses for one cycle, the cycle after the final acknowledge. It presents the attempt's address and the byte received after OP_FETCH, and `good_bytes` rises by one in that same cycle.
- R7: Before every attempt the target power is held off for exactly PWR_OFF cycles. Only the very first attempt of a run may wait longer. `attempts` rises by one as each attempt starts.
- R8: The address increases by one after each successful read, carrying into the high byte. After the end address is read, `done` rises and stays high with no further transfers until the next start. A start clears both counters.
- R9: A `start` pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| start_addr | input | 16 | First address to read |
| end_addr | input | 16 | Last address to read |
| xfer_go | output | 1 | One-cycle request for one debug byte transfer |
| xfer_send | output | 1 | 1: send `xfer_byte` to the target, 0: receive a byte |
| xfer_byte | output | 8 | Byte to send |
| xfer_ack | input | 1 | Transfer engine finished the requested transfer |
| xfer_rdata | input | 8 | Byte received, valid with `xfer_ack` |
| glitch_fire | output | 1 | One-cycle trigger for the fault pulse generator |
| tgt_pwr_en | output | 1 | Target power enable |
| rd_valid | output | 1 | One-cycle strobe for a successfully read byte |
| rd_addr | output | 16 | Address of the byte read |
| rd_data | output | 8 | Byte read |
| attempts | output | 32 | Attempts started in this run |
| good_bytes | output | 32 | Bytes read successfully in this run |
| done | output | 1 | End address has been read |

## Verification
The bench builds the block with PWR_OFF set to 3 and keeps the default command and opcode bytes and the lock bit at position 2. The short power-off window lets ten attempts fit in a few hundred cycles. A model of the transfer engine answers after one idle cycle and scripts the two status outcomes per attempt. It covers failures at the first check, failures at the second check, a failure where only the skipped second status would have been good, and a run from 0x00FE to 0x0101 that carries the address into the high byte. A second run with equal start and end addresses covers the single-byte read, counter clearing and an ignored start.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  // The exchange carries the address as two bytes, so the address width is fixed.
  localparam int ADDR_W = 16;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_PWR, ST_XFER, ST_DONE} gsr_state_e;

  // Step indices whose position the sequencing depends on.
  localparam logic [STEP_W-1:0] STP_CMD_A  = 4'd0;
  localparam logic [STEP_W-1:0] STP_STAT_A = 4'd6;
  localparam logic [STEP_W-1:0] STP_CMD_B  = 4'd7;
  localparam logic [STEP_W-1:0] STP_DATA   = 4'd9;
  localparam logic [STEP_W-1:0] STP_STAT_B = 4'd11;
endpackage

// File: rtl/gsr_step_rom.sv
module gsr_step_rom
  import gsr_pkg::*;
#(
  parameter logic [7:0] CMD_LONG   = 8'h57,
  parameter logic [7:0] CMD_SHORT  = 8'h55,
  parameter logic [7:0] CMD_STATUS = 8'h34,
  parameter logic [7:0] OP_LOAD    = 8'h90,
  parameter logic [7:0] OP_FETCH   = 8'hE0
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  output logic              send,
  output logic [7:0]        data
);
  always_comb begin
    send = 1'b1;
    data = 8'h00;
    case (step)
      4'd0:    data = CMD_LONG;
      4'd1:    data = OP_LOAD;
      4'd2:    data = addr[ADDR_W-1 -: 8];
      4'd3:    data = addr[7:0];
      4'd5:    data = CMD_STATUS;
      4'd7:    data = CMD_SHORT;
      4'd8:    data = OP_FETCH;
      4'd10:   data = CMD_STATUS;
      default: send = 1'b0;  // receive steps 4, 6, 9, 11
    endcase
  end
endmodule

// File: rtl/gsr_pwr_timer.sv
module gsr_pwr_timer #(
  parameter int OFF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expire
);
  localparam int CW = (OFF_CYC < 2) ? 1 : $clog2(OFF_CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (arm) begin
      cnt <= CW'(OFF_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0) && !arm;
endmodule

// File: rtl/gsr_tally.sv
module gsr_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_try,
  input  logic             inc_good,
  output logic [CNT_W-1:0] tries,
  output logic [CNT_W-1:0] goods
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tries <= '0;
      goods <= '0;
    end else begin
      if (inc_try)  tries <= tries + 1'b1;
      if (inc_good) goods <= goods + 1'b1;
    end
  end
endmodule

// File: rtl/gsr_read_seq.sv
module gsr_read_seq
  import gsr_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         PWR_OFF    = 4,
  parameter int         LOCK_BIT   = 2,
  parameter logic [7:0] CMD_LONG   = 8'h57,
  parameter logic [7:0] CMD_SHORT  = 8'h55,
  parameter logic [7:0] CMD_STATUS = 8'h34,
  parameter logic [7:0] OP_LOAD    = 8'h90,
  parameter logic [7:0] OP_FETCH   = 8'hE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       start_addr,
  input  logic [15:0]       end_addr,
  output logic              xfer_go,
  output logic              xfer_send,
  output logic [7:0]        xfer_byte,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rdata,
  output logic              glitch_fire,
  output logic              tgt_pwr_en,
  output logic              rd_valid,
  output logic [15:0]       rd_addr,
  output logic [7:0]        rd_data,
  output logic [CNT_W-1:0]  attempts,
  output logic [CNT_W-1:0]  good_bytes,
  output logic              done
);
  gsr_state_e        state;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] end_r;
  logic [7:0]        data_r;

  logic              ack_x, locked, fail, win, last, start_ok, arm, att_inc, expire;
  logic [STEP_W-1:0] rom_step;
  logic              rom_send;
  logic [7:0]        rom_byte;

  always_comb begin
    ack_x    = (state == ST_XFER) && xfer_ack;
    locked   = xfer_rdata[LOCK_BIT];
    fail     = ack_x && locked && (step == STP_STAT_A || step == STP_STAT_B);
    win      = ack_x && !locked && (step == STP_STAT_B);
    last     = (addr == end_r);
    start_ok = start && (state == ST_IDLE || state == ST_DONE);
    arm      = start_ok || fail || (win && !last);
    att_inc  = (state == ST_PWR) && expire;
    rom_step = (state == ST_XFER) ? step + 1'b1 : '0;
  end

  gsr_step_rom #(
    .CMD_LONG(CMD_LONG), .CMD_SHORT(CMD_SHORT), .CMD_STATUS(CMD_STATUS),
    .OP_LOAD(OP_LOAD), .OP_FETCH(OP_FETCH)
  ) u_rom (
    .step(rom_step), .addr(addr), .send(rom_send), .data(rom_byte)
  );

  gsr_pwr_timer #(.OFF_CYC(PWR_OFF)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .expire(expire)
  );

  gsr_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(start_ok), .inc_try(att_inc), .inc_good(win),
    .tries(attempts), .goods(good_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      step        <= '0;
      addr        <= '0;
      end_r       <= '0;
      data_r      <= '0;
      xfer_go     <= 1'b0;
      xfer_send   <= 1'b0;
      xfer_byte   <= '0;
      glitch_fire <= 1'b0;
      tgt_pwr_en  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_addr     <= '0;
      rd_data     <= '0;
      done        <= 1'b0;
    end else begin
      xfer_go     <= 1'b0;
      glitch_fire <= 1'b0;
      rd_valid    <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            addr  <= start_addr;
            end_r <= end_addr;
            done  <= 1'b0;
            state <= ST_PWR;
          end
        end
        ST_PWR: begin
          if (expire) begin
            tgt_pwr_en <= 1'b1;
            step       <= '0;
            xfer_go    <= 1'b1;
            xfer_send  <= rom_send;
            xfer_byte  <= rom_byte;
            state      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_ack) begin
            if (step == STP_CMD_A || step == STP_CMD_B) glitch_fire <= 1'b1;
            if (step == STP_DATA) data_r <= xfer_rdata;
            if (fail) begin
              tgt_pwr_en <= 1'b0;
              state      <= ST_PWR;
            end else if (win) begin
              rd_valid   <= 1'b1;
              rd_addr    <= addr;
              rd_data    <= data_r;
              tgt_pwr_en <= 1'b0;
              if (last) begin
                done  <= 1'b1;
                state <= ST_DONE;
              end else begin
                addr  <= addr + 1'b1;
                state <= ST_PWR;
              end
            end else begin
              step      <= step + 1'b1;
              xfer_go   <= 1'b1;
              xfer_send <= rom_send;
              xfer_byte <= rom_byte;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gsr_read_seq_chk.sv
module gsr_read_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_go,
  input logic             xfer_ack,
  input logic             glitch_fire,
  input logic             tgt_pwr_en,
  input logic             rd_valid,
  input logic [CNT_W-1:0] good_bytes,
  input logic             done
);
  // R3: a fault trigger only ever follows a completed transfer
  a_r3_glitch_after_ack: assert property (@(posedge clk) disable iff (rst)
    glitch_fire |-> $past(xfer_ack));

  // R2: one request per transfer, never two in a row
  a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> !xfer_go);

  // R7: no transfer is requested while the target is unpowered
  a_r7_powered_request: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> tgt_pwr_en);

  // R7: power is dropped only at the end of a transfer
  a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_pwr_en) |-> $past(xfer_ack));

  // R6: a read strobe follows an acknowledge and bumps the success count
  a_r6_strobe_after_ack: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(xfer_ack));
  a_r6_strobe_counts: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> good_bytes == $past(good_bytes) + 1'b1);

  // R8: a finished run stays quiet
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !xfer_go && !glitch_fire && !tgt_pwr_en);
endmodule

bind gsr_read_seq gsr_read_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .xfer_go(xfer_go), .xfer_ack(xfer_ack),
  .glitch_fire(glitch_fire), .tgt_pwr_en(tgt_pwr_en), .rd_valid(rd_valid),
  .good_bytes(good_bytes), .done(done)
);

// File: tb/gsr_read_seq_tb.sv
`timescale 1ns/1ps
module gsr_read_seq_tb;
  localparam int PWR_OFF = 3;
  localparam int NV = 10;
  // per attempt: bit1 = status after pointer load unlocked, bit0 = status after fetch unlocked
  localparam logic [1:0] VEC [0:NV-1] = '{2'b11, 2'b00, 2'b01, 2'b10, 2'b11,
                                          2'b10, 2'b00, 2'b11, 2'b01, 2'b11};

  logic clk = 0, rst = 1, start = 0;
  logic [15:0] start_addr = 0, end_addr = 0;
  logic xfer_go, xfer_send, xfer_ack, glitch_fire, tgt_pwr_en, rd_valid, done;
  logic [7:0] xfer_byte, xfer_rdata, rd_data;
  logic [15:0] rd_addr;
  logic [31:0] attempts, good_bytes;

  always #2.5 clk = ~clk;

  gsr_read_seq #(.PWR_OFF(PWR_OFF)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .xfer_go(xfer_go), .xfer_send(xfer_send), .xfer_byte(xfer_byte),
    .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata), .glitch_fire(glitch_fire),
    .tgt_pwr_en(tgt_pwr_en), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .attempts(attempts), .good_bytes(good_bytes), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  int stp = 0, last_step = -1, att_ix = 0, att_fin = 0;
  int gl_cnt = 0, rd_cnt = 0, lowcnt = 0, go_in_done = 0;
  bit in_att = 0, use_vec = 1, first_run = 1, pwr_q = 0;
  logic [1:0] cur_ok = 0, dir_ok = 2'b11;
  logic [15:0] exp_addr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] dfn(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  function automatic bit exp_send(input int s);
    return !(s == 4 || s == 6 || s == 9 || s == 11);
  endfunction

  function automatic logic [7:0] exp_byte(input int s, input logic [15:0] a);
    case (s)
      0: return 8'h57;  1: return 8'h90;  2: return a[15:8]; 3: return a[7:0];
      5: return 8'h34;  7: return 8'h55;  8: return 8'hE0;   10: return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  // Transfer engine and target model
  task automatic serve();
    logic [7:0] rd;
    if (stp == 0) begin
      att_ix++;
      cur_ok = use_vec ? VEC[att_ix-1] : dir_ok;
      in_att = 1;
    end
    if (stp == 7) chk(cur_ok[1], "R4 short command only after unlocked first status", stp, 6);
    chk(xfer_send == exp_send(stp), "R2 transfer direction", xfer_send, exp_send(stp));
    if (exp_send(stp))
      chk(xfer_byte == exp_byte(stp, exp_addr),
          (stp == 2 || stp == 3) ? "R2 R4 R5 R8 address byte" : "R2 command byte",
          xfer_byte, exp_byte(stp, exp_addr));
    case (stp)
      4:  rd = 8'h3C;
      6:  rd = cur_ok[1] ? 8'hB2 : 8'hB6;
      9:  rd = dfn(exp_addr);
      11: rd = cur_ok[0] ? 8'hB2 : 8'hB6;
      default: rd = 8'h00;
    endcase
    @(negedge clk);
    xfer_ack = 1; xfer_rdata = rd; last_step = stp;
    @(negedge clk);
    xfer_ack = 0;
    stp++;
  endtask

  initial begin
    xfer_ack = 0; xfer_rdata = 0;
    forever begin
      @(negedge clk);
      while (xfer_go) serve();
      if (!tgt_pwr_en) begin
        stp = 0;
        if (in_att) begin in_att = 0; att_fin++; end
      end
    end
  end

  // Output monitor
  always @(negedge clk) if (!rst) begin
    if (glitch_fire) begin
      gl_cnt++;
      chk(last_step == 0 || last_step == 7, "R3 glitch position", last_step, 0);
    end
    if (rd_valid) begin
      chk(rd_addr == exp_addr, "R6 read address", rd_addr, exp_addr);
      chk(rd_data == dfn(exp_addr), "R6 read data", rd_data, dfn(exp_addr));
      exp_addr = exp_addr + 1;
      rd_cnt++;
    end
    if (tgt_pwr_en && !pwr_q) begin
      if (!first_run) chk(lowcnt == PWR_OFF, "R7 power-off length", lowcnt, PWR_OFF);
      first_run = 0;
      lowcnt = 0;
    end
    if (!tgt_pwr_en) lowcnt++;
    pwr_q = tgt_pwr_en;
    if (done && xfer_go) go_in_done++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int exp_good, exp_gl;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!tgt_pwr_en, "R1 power off", tgt_pwr_en, 0);
    chk(!xfer_go && !glitch_fire && !rd_valid, "R1 strobes low",
        {xfer_go, glitch_fire, rd_valid}, 0);
    chk(!done, "R1 done low", done, 0);
    chk(attempts == 0 && good_bytes == 0, "R1 counters zero", attempts + good_bytes, 0);

    // Run 1: table of scripted attempts, 0x00FE..0x0101 crosses into the high byte
    start_addr = 16'h00FE; end_addr = 16'h0101; exp_addr = 16'h00FE;
    use_vec = 1; first_run = 1;
    start = 1; @(negedge clk); start = 0;
    exp_good = 0; exp_gl = 0;
    for (int i = 0; i < NV; i++) begin
      wait (att_fin == i + 1);
      if (VEC[i] == 2'b11) exp_good++;
      exp_gl += 1 + VEC[i][1];
      chk(attempts == i + 1, "R7 attempt count", attempts, i + 1);
      chk(good_bytes == exp_good, "R4 R5 R6 success count", good_bytes, exp_good);
    end
    @(negedge clk);
    chk(done, "R8 done after end address", done, 1);
    chk(rd_cnt == 4, "R6 reads reported", rd_cnt, 4);
    chk(exp_addr == 16'h0102, "R8 address carry", exp_addr, 16'h0102);
    chk(gl_cnt == exp_gl, "R3 glitch count", gl_cnt, exp_gl);
    repeat (10) @(negedge clk);
    chk(done && go_in_done == 0 && attempts == NV, "R8 done holds quietly",
        go_in_done, 0);

    // Run 2: single address, one ignored start while busy
    start_addr = 16'h1234; end_addr = 16'h1234; exp_addr = 16'h1234;
    use_vec = 0; dir_ok = 2'b11; first_run = 1;
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    chk(!done && attempts == 0, "R8 start clears counters", attempts, 0);
    repeat (18) @(negedge clk);
    start_addr = 16'h0000; end_addr = 16'h0005;
    start = 1; @(negedge clk); start = 0;
    wait (att_fin == NV + 1);
    @(negedge clk);
    chk(rd_cnt == 5 && rd_addr == 16'h1234, "R9 start ignored while busy", rd_addr, 16'h1234);
    chk(attempts == 1 && good_bytes == 1, "R8 single-byte run counters",
        attempts, 1);
    chk(done, "R8 single-byte run done", done, 1);
    chk(gl_cnt == exp_gl + 2, "R3 glitches in clean attempt", gl_cnt, exp_gl + 2);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule